// File: doc/BRIEF.md
# Dual-Clock FIFO with Reset Recovery

This block moves data words from a producer running on a write clock to a consumer running on an unrelated read clock. The two sides exchange their positions as Gray-coded pointers. Each pointer is one bit wider than the storage address and passes through a two-stage synchronizer into the other clock domain. The write side computes its fill level from its own pointer and the synchronized read pointer. From that level it drives a full flag and an almost-full flag. The read side does the same and drives an empty flag and an almost-empty flag. The almost-full and almost-empty levels are parameters.

Each side has its own reset input. For simple use, both inputs are driven from one common reset. That reset must be held for at least three cycles of the slower clock. After reset is released, each side keeps its ready output low for a fixed number of its own clock edges. The user waits for ready before reading or writing. A compile-time option adds a register stage after the storage read. This stage adds one read-clock cycle of data latency and does not change when any flag moves. A write attempted while full, and a read attempted while empty, are dropped. Each such attempt sets a sticky error indicator on its side.

Top module: `dual_clock_fifo`

## Requirements
- R1: While the common reset has been held for three cycles of the slower clock: rdEmpty and rdAlmostEmpty are 1; wrFull, wrAlmostFull, wrOverflow, rdUnderflow, wrReady and rdReady are 0. Both pointers return to zero, so data stored before reset is discarded and the FIFO reads as empty afterwards.
- R2: When OUT_REG is 0, the word for a read accepted at a read-clock edge is on rdData right after that edge. When OUT_REG is 1, it appears one read-clock edge later. Words leave in the order they were written, and rdData holds its value when no read is accepted.
- R3: Every flag output takes the same value in the same cycle whether OUT_REG is 0 or 1.
- R4: wrReady and rdReady are 0 during reset. After release, each goes to 1 at the third rising edge of its own clock that sees its reset low (RECOVER_CYCLES = 3).
- R5: wrFull is 1 when the write-side occupancy equals DEPTH (8). A write attempted while wrFull is 1 is dropped, and it sets wrOverflow, which stays 1 until reset.
- R6: A read attempted while rdEmpty is 1 is dropped and does not move the read pointer. It sets rdUnderflow, which stays 1 until reset.
- R7: wrAlmostFull is 1 exactly when the write-side occupancy is at least AFULL_LEVEL (6).
- R8: rdAlmostEmpty is 1 exactly when the read-side occupancy is at most AEMPTY_LEVEL (2).
- R9: Each Gray pointer changes at most one bit per clock. Flags are never optimistic: wrFull is 1 whenever the FIFO truly holds DEPTH words, and rdEmpty is 1 whenever it truly holds none. Once both sides have been idle for several read cycles, every flag matches the true occupancy.
- R10: A write or read presented while that side's ready is 0 is dropped and sets no error indicator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| wrRst | input | 1 | Write-side synchronous reset, active high |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Word to store |
| wrFull | output | 1 | No free slot as seen by the write side |
| wrAlmostFull | output | 1 | Write-side occupancy at or above AFULL_LEVEL |
| wrOverflow | output | 1 | Sticky: a write was dropped while full |
| wrReady | output | 1 | Write side out of reset recovery |
| rdClk | input | 1 | Read-side clock |
| rdRst | input | 1 | Read-side synchronous reset, active high |
| rdEn | input | 1 | Read request |
| rdData | output | DATA_W | Word read out |
| rdEmpty | output | 1 | Nothing to read as seen by the read side |
| rdAlmostEmpty | output | 1 | Read-side occupancy at or below AEMPTY_LEVEL |
| rdUnderflow | output | 1 | Sticky: a read was dropped while empty |
| rdReady | output | 1 | Read side out of reset recovery |

## Verification
The case that matters most is a write arriving against a full flag while the read side is removing a word in the same stretch of time. The write side still sees the stale read pointer, so it has to drop the write and raise overflow, even though a slot is already being freed. This is provoked by a long phase of random, overlapping traffic in which the write clock is faster than the read clock and writes are requested more often than reads. The model decides whether each write was accepted from the full flag seen at the port before the edge. It then checks that every word read, from both output-register variants, is the next word in the model queue. This shows that no dropped write ever reached storage and no accepted write was lost.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

  // Per-domain strobes from control to datapath
  typedef struct packed {
    logic wrStrobe;   // store wrData at the write address this wrClk edge
    logic rdStrobe;   // capture the word at the read address this rdClk edge
  } dcfStrobe_t;

endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/dcf_recover.sv
`timescale 1ns/1ps
module dcf_recover #(
  parameter int CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  output logic ready
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                       cnt <= '0;
    else if (cnt != CW'(CYCLES))   cnt <= cnt + 1'b1;
  end

  assign ready = (cnt == CW'(CYCLES));

  // R4
  ready_low_in_rst_chk: assert property (@(posedge clk) rst |=> !ready)
    else $error("ready high after a reset cycle");

endmodule

// File: rtl/dcf_ctrl.sv
`timescale 1ns/1ps
module dcf_ctrl
  import dcf_pkg::*;
#(
  parameter int ADDR_W         = 3,
  parameter int AFULL_LEVEL    = 6,
  parameter int AEMPTY_LEVEL   = 2,
  parameter int RECOVER_CYCLES = 3
) (
  input  logic              wrClk,
  input  logic              wrRst,
  input  logic              wrEn,
  output logic              wrFull,
  output logic              wrAlmostFull,
  output logic              wrOverflow,
  output logic              wrReady,
  output logic [ADDR_W-1:0] wrAddr,
  input  logic              rdClk,
  input  logic              rdRst,
  input  logic              rdEn,
  output logic              rdEmpty,
  output logic              rdAlmostEmpty,
  output logic              rdUnderflow,
  output logic              rdReady,
  output logic [ADDR_W-1:0] rdAddr,
  output dcfStrobe_t        stb
);

  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  function automatic logic [PW-1:0] grayToBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PW-1:0] wBin, wGray, wBinNext, rGrayAtW, rBinAtW, wOcc;
  logic          wrAccept;

  dcf_recover #(.CYCLES(RECOVER_CYCLES)) wrRecover_i (
    .clk(wrClk), .rst(wrRst), .ready(wrReady));

  dcf_sync #(.W(PW), .STAGES(2)) rdPtrSync_i (
    .clk(wrClk), .rst(wrRst), .din(rGray), .dout(rGrayAtW));

  assign rBinAtW      = grayToBin(rGrayAtW);
  assign wOcc         = wBin - rBinAtW;
  assign wrFull       = (wOcc == PW'(DEPTH));
  assign wrAlmostFull = (wOcc >= PW'(AFULL_LEVEL));
  assign wrAccept     = wrEn && wrReady && !wrFull;
  assign wBinNext     = wBin + 1'b1;
  assign wrAddr       = wBin[ADDR_W-1:0];

  always_ff @(posedge wrClk) begin
    if (wrRst) begin
      wBin       <= '0;
      wGray      <= '0;
      wrOverflow <= 1'b0;
    end else begin
      if (wrAccept) begin
        wBin  <= wBinNext;
        wGray <= wBinNext ^ (wBinNext >> 1);
      end
      if (wrEn && wrReady && wrFull) wrOverflow <= 1'b1;
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rBin, rGray, rBinNext, wGrayAtR, wBinAtR, rOcc;
  logic          rdAccept;

  dcf_recover #(.CYCLES(RECOVER_CYCLES)) rdRecover_i (
    .clk(rdClk), .rst(rdRst), .ready(rdReady));

  dcf_sync #(.W(PW), .STAGES(2)) wrPtrSync_i (
    .clk(rdClk), .rst(rdRst), .din(wGray), .dout(wGrayAtR));

  assign wBinAtR       = grayToBin(wGrayAtR);
  assign rOcc          = wBinAtR - rBin;
  assign rdEmpty       = (rOcc == '0);
  assign rdAlmostEmpty = (rOcc <= PW'(AEMPTY_LEVEL));
  assign rdAccept      = rdEn && rdReady && !rdEmpty;
  assign rBinNext      = rBin + 1'b1;
  assign rdAddr        = rBin[ADDR_W-1:0];

  always_ff @(posedge rdClk) begin
    if (rdRst) begin
      rBin        <= '0;
      rGray       <= '0;
      rdUnderflow <= 1'b0;
    end else begin
      if (rdAccept) begin
        rBin  <= rBinNext;
        rGray <= rBinNext ^ (rBinNext >> 1);
      end
      if (rdEn && rdReady && rdEmpty) rdUnderflow <= 1'b1;
    end
  end

  always_comb begin
    stb.wrStrobe = wrAccept;
    stb.rdStrobe = rdAccept;
  end

  // R5
  full_hold_chk: assert property (@(posedge wrClk) disable iff (wrRst)
    (wrFull && wrEn) |=> $stable(wBin)) else $error("write pointer moved while full");
  // R5
  ovf_sticky_chk: assert property (@(posedge wrClk) disable iff (wrRst)
    wrOverflow |=> wrOverflow) else $error("overflow cleared without reset");
  // R6
  empty_hold_chk: assert property (@(posedge rdClk) disable iff (rdRst)
    (rdEmpty && rdEn) |=> $stable(rBin)) else $error("read pointer moved while empty");
  // R6
  unf_sticky_chk: assert property (@(posedge rdClk) disable iff (rdRst)
    rdUnderflow |=> rdUnderflow) else $error("underflow cleared without reset");
  // R7
  full_implies_afull_chk: assert property (@(posedge wrClk) disable iff (wrRst)
    wrFull |-> wrAlmostFull) else $error("full without almost-full");
  // R9
  wgray_step_chk: assert property (@(posedge wrClk) disable iff (wrRst)
    $countones(wGray ^ $past(wGray)) <= 1) else $error("write gray jumped");
  // R9
  rgray_step_chk: assert property (@(posedge rdClk) disable iff (rdRst)
    $countones(rGray ^ $past(rGray)) <= 1) else $error("read gray jumped");
  // R10
  idle_when_unready_chk: assert property (@(posedge wrClk) disable iff (wrRst)
    !wrReady |=> $stable(wBin)) else $error("write accepted while not ready");

endmodule

// File: rtl/dcf_datapath.sv
`timescale 1ns/1ps
module dcf_datapath
  import dcf_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3,
  parameter bit OUT_REG = 1'b0
) (
  input  logic              wrClk,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdClk,
  input  logic              rdRst,
  input  logic [ADDR_W-1:0] rdAddr,
  input  dcfStrobe_t        stb,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] readReg;

  always_ff @(posedge wrClk) begin
    if (stb.wrStrobe) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk) begin
    if (rdRst)             readReg <= '0;
    else if (stb.rdStrobe) readReg <= mem[rdAddr];
  end

  generate
    if (OUT_REG) begin : g_outReg
      logic [DATA_W-1:0] outReg;
      always_ff @(posedge rdClk) begin
        if (rdRst) outReg <= '0;
        else       outReg <= readReg;
      end
      assign rdData = outReg;
    end else begin : g_direct
      assign rdData = readReg;
    end
  endgenerate

  // R2
  data_hold_chk: assert property (@(posedge rdClk) disable iff (rdRst)
    !stb.rdStrobe |=> $stable(readReg)) else $error("read word changed without a read");

endmodule

// File: rtl/dual_clock_fifo.sv
`timescale 1ns/1ps
module dual_clock_fifo
  import dcf_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int ADDR_W         = 3,
  parameter int AFULL_LEVEL    = 6,
  parameter int AEMPTY_LEVEL   = 2,
  parameter int RECOVER_CYCLES = 3,
  parameter bit OUT_REG        = 1'b0
) (
  input  logic              wrClk,
  input  logic              wrRst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrFull,
  output logic              wrAlmostFull,
  output logic              wrOverflow,
  output logic              wrReady,
  input  logic              rdClk,
  input  logic              rdRst,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEmpty,
  output logic              rdAlmostEmpty,
  output logic              rdUnderflow,
  output logic              rdReady
);

  dcfStrobe_t        stb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  dcf_ctrl #(
    .ADDR_W(ADDR_W), .AFULL_LEVEL(AFULL_LEVEL),
    .AEMPTY_LEVEL(AEMPTY_LEVEL), .RECOVER_CYCLES(RECOVER_CYCLES)
  ) ctrl_i (
    .wrClk(wrClk), .wrRst(wrRst), .wrEn(wrEn),
    .wrFull(wrFull), .wrAlmostFull(wrAlmostFull), .wrOverflow(wrOverflow),
    .wrReady(wrReady), .wrAddr(wrAddr),
    .rdClk(rdClk), .rdRst(rdRst), .rdEn(rdEn),
    .rdEmpty(rdEmpty), .rdAlmostEmpty(rdAlmostEmpty), .rdUnderflow(rdUnderflow),
    .rdReady(rdReady), .rdAddr(rdAddr), .stb(stb)
  );

  dcf_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OUT_REG(OUT_REG)
  ) dpath_i (
    .wrClk(wrClk), .wrAddr(wrAddr), .wrData(wrData),
    .rdClk(rdClk), .rdRst(rdRst), .rdAddr(rdAddr),
    .stb(stb), .rdData(rdData)
  );

endmodule

// File: tb/dual_clock_fifo_tb_top.sv
`timescale 1ns/1ps
module dual_clock_fifo_tb_top;

  localparam int DW = 8, AW = 3, DEPTH = 8, AF = 6, AE = 2;

  logic wrClk = 1'b0, rdClk = 1'b0;
  always #2   wrClk = ~wrClk;   // 250 MHz
  always #3.5 rdClk = ~rdClk;   // slower read side

  logic wrRst = 1'b1, rdRst = 1'b1, wrEn = 1'b0, rdEn = 1'b0;
  logic [DW-1:0] wrData = '0;

  logic [DW-1:0] rdData0, rdData1;
  logic wrFull0, wrAF0, wrOvf0, wrRdy0, rdEmp0, rdAE0, rdUnf0, rdRdy0;
  logic wrFull1, wrAF1, wrOvf1, wrRdy1, rdEmp1, rdAE1, rdUnf1, rdRdy1;

  dual_clock_fifo #(.DATA_W(DW), .ADDR_W(AW), .AFULL_LEVEL(AF), .AEMPTY_LEVEL(AE),
                    .RECOVER_CYCLES(3), .OUT_REG(1'b0)) dut_i (
    .wrClk(wrClk), .wrRst(wrRst), .wrEn(wrEn), .wrData(wrData),
    .wrFull(wrFull0), .wrAlmostFull(wrAF0), .wrOverflow(wrOvf0), .wrReady(wrRdy0),
    .rdClk(rdClk), .rdRst(rdRst), .rdEn(rdEn), .rdData(rdData0),
    .rdEmpty(rdEmp0), .rdAlmostEmpty(rdAE0), .rdUnderflow(rdUnf0), .rdReady(rdRdy0));

  dual_clock_fifo #(.DATA_W(DW), .ADDR_W(AW), .AFULL_LEVEL(AF), .AEMPTY_LEVEL(AE),
                    .RECOVER_CYCLES(3), .OUT_REG(1'b1)) dut_reg_i (
    .wrClk(wrClk), .wrRst(wrRst), .wrEn(wrEn), .wrData(wrData),
    .wrFull(wrFull1), .wrAlmostFull(wrAF1), .wrOverflow(wrOvf1), .wrReady(wrRdy1),
    .rdClk(rdClk), .rdRst(rdRst), .rdEn(rdEn), .rdData(rdData1),
    .rdEmpty(rdEmp1), .rdAlmostEmpty(rdAE1), .rdUnderflow(rdUnf1), .rdReady(rdRdy1));

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // behavioural reference model
  int q[$];
  int nextData = 1;
  int pend1 = 0, pend2 = 0;
  bit pv1 = 0, pv2 = 0;
  int wrBudget = 0, rdBudget = 0, wrMode = 0, rdMode = 0;
  bit wrForce = 0;

  always @(negedge wrClk) begin : wrSide
    bit want;
    if (wrRst) begin
      wrEn = 1'b0;
      q.delete();
    end else begin
      chk("R3", "wrFull across variants", int'(wrFull1), int'(wrFull0));
      chk("R3", "wrAlmostFull across variants", int'(wrAF1), int'(wrAF0));
      if (wrRdy0 && q.size() == DEPTH) chk("R9", "wrFull while truly full", int'(wrFull0), 1);
      want = (wrBudget > 0) && (wrMode == 1 || (wrMode == 2 && ($urandom % 3) != 0));
      if (wrForce) begin
        wrEn = 1'b1; wrData = 8'hEE;
      end else if (want && wrRdy0) begin
        wrEn = 1'b1; wrData = 8'(nextData);
        if (!wrFull0) begin q.push_back(nextData & 255); nextData++; end
        wrBudget--;
      end else begin
        wrEn = 1'b0;
      end
    end
  end

  always @(negedge rdClk) begin : rdSide
    bit want;
    if (rdRst) begin
      rdEn = 1'b0; pv1 = 0; pv2 = 0;
    end else begin
      if (pv1) chk("R2", "rdData no out reg", int'(rdData0), pend1);
      if (pv2) chk("R2", "rdData with out reg", int'(rdData1), pend2);
      chk("R3", "rdEmpty across variants", int'(rdEmp1), int'(rdEmp0));
      chk("R3", "rdAlmostEmpty across variants", int'(rdAE1), int'(rdAE0));
      if (rdRdy0 && q.size() == 0) chk("R9", "rdEmpty while truly empty", int'(rdEmp0), 1);
      pend2 = pend1; pv2 = pv1; pv1 = 0;
      want = (rdBudget > 0) && (rdMode == 1 || (rdMode == 2 && ($urandom % 3) != 0));
      if (want && rdRdy0) begin
        rdEn = 1'b1;
        if (!rdEmp0) begin
          if (q.size() == 0) chk("R9", "read side saw data model lacks", 1, 0);
          else begin pend1 = q.pop_front(); pv1 = 1; end
        end
        rdBudget--;
      end else begin
        rdEn = 1'b0;
      end
    end
  end

  task automatic doReset(bit forceWrite);
    fork
      begin @(negedge wrClk); wrRst = 1'b1; end
      begin @(negedge rdClk); rdRst = 1'b1; end
    join
    repeat (4) @(negedge rdClk);
    chk("R1", "rdEmpty in reset", int'(rdEmp0), 1);
    chk("R1", "rdAlmostEmpty in reset", int'(rdAE0), 1);
    chk("R1", "wrFull in reset", int'(wrFull0), 0);
    chk("R1", "wrAlmostFull in reset", int'(wrAF0), 0);
    chk("R1", "wrOverflow in reset", int'(wrOvf0), 0);
    chk("R1", "rdUnderflow in reset", int'(rdUnf0), 0);
    chk("R4", "wrReady in reset", int'(wrRdy0), 0);
    chk("R4", "rdReady in reset", int'(rdRdy0), 0);
    fork
      begin
        @(negedge wrClk); wrRst = 1'b0;
        @(negedge wrClk); chk("R4", "wrReady after 1 edge", int'(wrRdy0), 0);
        if (forceWrite) wrForce = 1;
        @(negedge wrClk); chk("R4", "wrReady after 2 edges", int'(wrRdy0), 0);
        wrForce = 0;
        @(negedge wrClk); chk("R4", "wrReady after 3 edges", int'(wrRdy0), 1);
      end
      begin
        @(negedge rdClk); rdRst = 1'b0;
        @(negedge rdClk); chk("R4", "rdReady after 1 edge", int'(rdRdy0), 0);
        @(negedge rdClk); chk("R4", "rdReady after 2 edges", int'(rdRdy0), 0);
        @(negedge rdClk); chk("R4", "rdReady after 3 edges", int'(rdRdy0), 1);
      end
    join
  endtask

  task automatic runWr(int n, int mode);
    wrMode = mode; wrBudget = n;
    wait (wrBudget == 0);
    wrMode = 0;
  endtask

  task automatic runRd(int n, int mode);
    rdMode = mode; rdBudget = n;
    wait (rdBudget == 0);
    rdMode = 0;
  endtask

  // idle both sides, then compare every flag with the exact model level
  task automatic settle(string req);
    int lvl;
    repeat (6) @(negedge rdClk);
    lvl = q.size();
    chk(req, "rdEmpty settled", int'(rdEmp0), int'(lvl == 0));
    chk(req, "rdAlmostEmpty settled", int'(rdAE0), int'(lvl <= AE));
    @(negedge wrClk);
    chk(req, "wrFull settled", int'(wrFull0), int'(lvl == DEPTH));
    chk(req, "wrAlmostFull settled", int'(wrAF0), int'(lvl >= AF));
  endtask

  initial begin : watchdog
    #800000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin : main
    doReset(1'b1);
    settle("R10");
    chk("R10", "write while not ready stored nothing", int'(rdEmp0), 1);
    chk("R10", "no overflow from unready write", int'(wrOvf0), 0);

    runWr(DEPTH + 2, 1);
    settle("R5");
    chk("R5", "model level at full", q.size(), DEPTH);
    chk("R5", "wrFull after 8 writes", int'(wrFull0), 1);
    chk("R5", "wrOverflow after extra writes", int'(wrOvf0), 1);
    chk("R7", "wrAlmostFull at 8", int'(wrAF0), 1);

    runRd(DEPTH + 2, 1);
    settle("R6");
    chk("R6", "rdUnderflow after extra reads", int'(rdUnf0), 1);
    chk("R5", "wrOverflow still sticky", int'(wrOvf0), 1);

    runWr(2, 1); settle("R8");
    chk("R8", "rdAlmostEmpty at level 2", int'(rdAE0), 1);
    runWr(1, 1); settle("R8");
    chk("R8", "rdAlmostEmpty at level 3", int'(rdAE0), 0);
    runWr(2, 1); settle("R7");
    chk("R7", "wrAlmostFull at level 5", int'(wrAF0), 0);
    runWr(1, 1); settle("R7");
    chk("R7", "wrAlmostFull at level 6", int'(wrAF0), 1);
    runWr(1, 1); settle("R5");
    chk("R5", "wrFull at level 7", int'(wrFull0), 0);
    runRd(7, 1); settle("R9");

    fork
      runWr(900, 2);
      runRd(600, 2);
    join
    settle("R9");
    runRd(DEPTH, 1); settle("R9");

    runWr(4, 1); settle("R9");
    doReset(1'b0);
    settle("R1");
    chk("R1", "empty after reset with data", int'(rdEmp0), 1);
    chk("R1", "overflow cleared", int'(wrOvf0), 0);
    chk("R1", "underflow cleared", int'(rdUnf0), 0);
    runWr(3, 1); settle("R2");
    runRd(3, 1); settle("R2");
    repeat (3) @(negedge rdClk);
    finish();
  end

endmodule